// File: doc/BRIEF.md
# SPI Slave Address Filter

This block sits between the receive shifter of an SPI slave and its receive buffer and decides, once per transaction, whether the transaction is meant for this device. When slave operation and the address-checking frame format are both selected, the first character that arrives after the select line falls is compared with a programmed 8-bit address.

On a match, the block does four things. It hands that character to the receive buffer, pulses receive-complete, and turns on the MISO output driver. If the device is asleep, it also raises a wake request. The remaining characters of that transaction are then passed through. On a mismatch, the block does not forward any character of the transaction and keeps MISO tri-stated until select goes high again.

With the filter off, characters are forwarded unconditionally while select is low. Every output is registered, so each result appears one clock after the strobe or select change that caused it.

Top module: `spi_addr_gate`

## Requirements
- R1: With the filter off (`slave_mode`=0 or `addr_fmt`=0), every character strobed while `sel_n` is low is pushed one cycle later, `rxc` stays 0, and `miso_oe` follows `slave_mode & !sel_n` one cycle later.
- R2: With the filter on, only the first character after `sel_n` falls is compared. Its bits [7:0] are compared with `addr_val`.
- R3: On a match, the cycle after the strobe shows `rx_push`=1 and `rxc`=1, and `rx_data` carries the address character itself.
- R4: After a match, `miso_oe` is 1 from the cycle after the strobe until the cycle after `sel_n` is seen high.
- R5: On a mismatch, no character of that transaction is pushed, `rxc` stays 0, and `miso_oe` stays 0.
- R6: When `wide_chr`=1, bit 8 of `chr_in` does not affect the compare and is kept in `rx_data`. When `wide_chr`=0, `rx_data[8]` is 0.
- R7: `wake_req` pulses together with `rxc` when a match happens with `asleep`=1. It stays 0 when `asleep`=0.
- R8: Characters after an accepted address are pushed, and `rxc` stays 0 for them.
- R9: `sel_n` high returns the filter to waiting for an address, so each transaction is judged on its own. A strobe while `sel_n` is high is ignored.
- R10: After reset, `miso_oe`, `rx_push`, `rx_data`, `rxc` and `wake_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slave_mode | input | 1 | 1 = port operates as slave |
| addr_fmt | input | 1 | 1 = address-checking frame format selected |
| wide_chr | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| asleep | input | 1 | Device is in a sleep state |
| sel_n | input | 1 | Slave select, active low, synchronous to clk |
| chr_vld | input | 1 | One-cycle strobe: a full character is in `chr_in` |
| chr_in | input | 9 | Received character |
| addr_val | input | 8 | Programmed device address |
| miso_oe | output | 1 | Enable for the MISO output driver |
| rx_push | output | 1 | Write strobe into the receive buffer |
| rx_data | output | 9 | Character written with `rx_push` |
| rxc | output | 1 | Receive-complete pulse on an address match |
| wake_req | output | 1 | Wake pulse on a match while asleep |

## Verification
The assertions assume three things about the inputs. `chr_vld` is a single-cycle strobe. `sel_n` is already synchronised to `clk`. The configuration inputs and `addr_val` do not change while `sel_n` is low.

The stimulus keeps to these assumptions. It sets the configuration and address only while select is high, and it drops each strobe after one cycle. Each transaction sends its characters spaced apart and then raises select before the next one starts. The sweep covers all 512 first-character values for three addresses, both character widths and both sleep states.

// File: rtl/spi_af_pkg.sv
package spi_af_pkg;

    // Per-transaction verdict of the address filter
    typedef enum logic [1:0] {
        PH_HUNT = 2'd0,   // waiting for the first character
        PH_TAKE = 2'd1,   // address matched, transaction accepted
        PH_DROP = 2'd2    // address missed, transaction ignored
    } phase_e;

endpackage

// File: rtl/spi_af_cmp.sv
module spi_af_cmp #(
    parameter int CHAR_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic [CHAR_W-1:0] chr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wide,
    output logic              hit,
    output logic [CHAR_W-1:0] data
);

    // Only the low address bits take part in the compare (R2, R6)
    assign hit = (chr[ADDR_W-1:0] == addr);

    generate
        if (CHAR_W > ADDR_W) begin : g_wide
            localparam int EXTRA_W = CHAR_W - ADDR_W;
            assign data = wide ? chr : {{EXTRA_W{1'b0}}, chr[ADDR_W-1:0]};
        end else begin : g_narrow
            logic unused_wide;
            assign unused_wide = wide;
            assign data = chr;
        end
    endgenerate

endmodule

// File: rtl/spi_af_phase.sv
module spi_af_phase
    import spi_af_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   filt_en,
    input  logic   sel_n,
    input  logic   chr_vld,
    input  logic   hit,
    output phase_e phase_q,
    output logic   is_first
);

    phase_e phase_d;

    assign is_first = filt_en && !sel_n && chr_vld && (phase_q == PH_HUNT);

    always_comb begin
        phase_d = phase_q;
        if (!filt_en || sel_n) begin
            phase_d = PH_HUNT;
        end else if (is_first) begin
            phase_d = hit ? PH_TAKE : PH_DROP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_HUNT;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R9: deselect always rearms the filter
    p_rearm_on_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (phase_q == PH_HUNT));

    // R2: a verdict, once taken, holds until select rises
    p_verdict_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !sel_n && phase_q != PH_HUNT) |=> (phase_q == $past(phase_q)));

endmodule

// File: rtl/spi_addr_gate.sv
module spi_addr_gate
    import spi_af_pkg::*;
#(
    parameter int CHAR_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slave_mode,
    input  logic              addr_fmt,
    input  logic              wide_chr,
    input  logic              asleep,
    input  logic              sel_n,
    input  logic              chr_vld,
    input  logic [CHAR_W-1:0] chr_in,
    input  logic [ADDR_W-1:0] addr_val,
    output logic              miso_oe,
    output logic              rx_push,
    output logic [CHAR_W-1:0] rx_data,
    output logic              rxc,
    output logic              wake_req
);

    typedef struct packed {
        logic              oe;
        logic              push;
        logic [CHAR_W-1:0] data;
        logic              rxc;
        logic              wake;
    } out_t;

    out_t        out_d, out_q;
    logic        filt_en;
    logic        hit;
    logic        is_first;
    logic [CHAR_W-1:0] cmp_data;
    phase_e      phase_q;

    assign filt_en = slave_mode && addr_fmt;

    spi_af_cmp #(
        .CHAR_W(CHAR_W),
        .ADDR_W(ADDR_W)
    ) u_cmp (
        .chr  (chr_in),
        .addr (addr_val),
        .wide (wide_chr),
        .hit  (hit),
        .data (cmp_data)
    );

    spi_af_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .filt_en  (filt_en),
        .sel_n    (sel_n),
        .chr_vld  (chr_vld),
        .hit      (hit),
        .phase_q  (phase_q),
        .is_first (is_first)
    );

    always_comb begin
        out_d      = '0;
        out_d.data = out_q.data;
        if (!filt_en) begin
            out_d.push = chr_vld && !sel_n;
            out_d.oe   = slave_mode && !sel_n;
        end else if (!sel_n) begin
            if (is_first) begin
                out_d.push = hit;
                out_d.rxc  = hit;
                out_d.wake = hit && asleep;
                out_d.oe   = hit;
            end else if (phase_q == PH_TAKE) begin
                out_d.push = chr_vld;
                out_d.oe   = 1'b1;
            end
        end
        if (out_d.push) begin
            out_d.data = cmp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign miso_oe  = out_q.oe;
    assign rx_push  = out_q.push;
    assign rx_data  = out_q.data;
    assign rxc      = out_q.rxc;
    assign wake_req = out_q.wake;

    p_rxc_with_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rxc |-> (rx_push && miso_oe));

    p_wake_with_rxc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> rxc);

    p_drop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_en && !sel_n && phase_q == PH_DROP) |=> (!rx_push && !miso_oe));

    p_rxc_first_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TAKE) |=> !rxc);

    p_deselect_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!miso_oe && !rx_push && !rxc));

    p_off_no_rxc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_en |=> !rxc);

endmodule

// File: tb/spi_addr_gate_bench.sv
module spi_addr_gate_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slave_mode = 1'b0;
    logic       addr_fmt = 1'b0;
    logic       wide_chr = 1'b0;
    logic       asleep = 1'b0;
    logic       sel_n = 1'b1;
    logic       chr_vld = 1'b0;
    logic [8:0] chr_in = '0;
    logic [7:0] addr_val = '0;
    logic       miso_oe, rx_push, rxc, wake_req;
    logic [8:0] rx_data;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_addr_gate u_spi_addr_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .slave_mode (slave_mode),
        .addr_fmt   (addr_fmt),
        .wide_chr   (wide_chr),
        .asleep     (asleep),
        .sel_n      (sel_n),
        .chr_vld    (chr_vld),
        .chr_in     (chr_in),
        .addr_val   (addr_val),
        .miso_oe    (miso_oe),
        .rx_push    (rx_push),
        .rx_data    (rx_data),
        .rxc        (rxc),
        .wake_req   (wake_req)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Strobe one character; returns sampled just after the capturing edge
    task automatic strobe(input logic [8:0] c);
        @(negedge clk);
        chr_vld = 1'b1;
        chr_in  = c;
        @(negedge clk);
        chr_vld = 1'b0;
    endtask

    task automatic set_sel(input logic v);
        @(negedge clk);
        sel_n = v;
        @(negedge clk);
    endtask

    task automatic filtered_txn(input logic [7:0] a, input logic [8:0] c,
                                input logic w, input logic s);
        logic       h;
        logic [8:0] c2;
        addr_val = a;
        wide_chr = w;
        asleep   = s;
        h  = (c[7:0] == a);
        c2 = ~c;
        set_sel(1'b0);
        chk("R5", "oe before address", {31'b0, miso_oe}, 0);
        strobe(c);
        chk("R3", "push on first", {31'b0, rx_push}, {31'b0, h});
        chk("R3", "rxc on first", {31'b0, rxc}, {31'b0, h});
        chk("R4", "oe after first", {31'b0, miso_oe}, {31'b0, h});
        chk("R7", "wake", {31'b0, wake_req}, {31'b0, h & s});
        if (h) chk("R6", "address data", {23'b0, rx_data}, {23'b0, w ? c : {1'b0, c[7:0]}});
        strobe(c2);
        chk("R8", "push on second", {31'b0, rx_push}, {31'b0, h});
        chk("R8", "no rxc on second", {31'b0, rxc}, 0);
        chk("R5", "oe held", {31'b0, miso_oe}, {31'b0, h});
        if (h) chk("R6", "second data", {23'b0, rx_data}, {23'b0, w ? c2 : {1'b0, c2[7:0]}});
        @(negedge clk);
        sel_n = 1'b1;
        @(negedge clk);
        chk("R4", "oe off after deselect", {31'b0, miso_oe}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "oe", {31'b0, miso_oe}, 0);
        chk("R10", "push", {31'b0, rx_push}, 0);
        chk("R10", "data", {23'b0, rx_data}, 0);
        chk("R10", "rxc", {31'b0, rxc}, 0);
        chk("R10", "wake", {31'b0, wake_req}, 0);
        rst_n = 1'b1;

        // Filter-off modes: pass-through (R1)
        for (int m = 0; m < 3; m++) begin
            slave_mode = (m == 1);
            addr_fmt   = (m != 2) ? (m == 1 ? 1'b0 : 1'b1) : 1'b0;
            wide_chr   = 1'b1;
            addr_val   = 8'h3C;
            set_sel(1'b0);
            chk("R1", "oe follows mode", {31'b0, miso_oe}, {31'b0, slave_mode});
            for (int c = 0; c < 512; c += 37) begin
                strobe(c[8:0]);
                chk("R1", "push", {31'b0, rx_push}, 1);
                chk("R1", "data", {23'b0, rx_data}, c);
                chk("R1", "rxc", {31'b0, rxc}, 0);
            end
            set_sel(1'b1);
            chk("R1", "oe off", {31'b0, miso_oe}, 0);
        end

        // Filter on: sweep every first character
        slave_mode = 1'b1;
        addr_fmt   = 1'b1;
        for (int ai = 0; ai < 3; ai++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 2; s++) begin
                    for (int c = 0; c < 512; c++) begin
                        filtered_txn((ai == 0) ? 8'h00 : (ai == 1) ? 8'h5A : 8'hFF,
                                     c[8:0], w[0], s[0]);
                    end
                end
            end
        end

        // R9: strobe while deselected is ignored, then a fresh transaction matches
        addr_val = 8'h21;
        strobe(9'h021);
        chk("R9", "push while deselected", {31'b0, rx_push}, 0);
        chk("R9", "rxc while deselected", {31'b0, rxc}, 0);
        filtered_txn(8'h21, 9'h0FE, 1'b1, 1'b0);
        filtered_txn(8'h21, 9'h121, 1'b1, 1'b1);
        chk("R2", "fresh match after miss", {31'b0, miso_oe}, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule